// File: doc/BRIEF.md
# Multi-Accept Out-of-Order Issue Queue

This block holds decoded instructions between dispatch and the execution ports. Each cycle it can take in several new instructions. Each instruction carries a payload, a set of source tags and one ready bit per source. Result-tag broadcasts set the ready bits of the sources that match. An entry becomes a candidate once every one of its sources is ready. Only the oldest few entries, called the issue window, are considered for issue.

Among ready candidates in the window, older entries are granted first. Each granted entry takes the lowest-numbered free execution port that is still unclaimed. The entries that remain slide toward the bottom every cycle so that age order is kept. Newly accepted instructions are placed directly above them.

A parameter selects between two ordering rules:
- **Out of order:** any ready entry in the window may issue.
- **In order:** an entry may issue only if every older entry issues in the same cycle.

Dispatch uses the free-entry count to throttle itself. A flush input discards the whole contents of the queue.

Top module: `multi_accept_issue_queue`

## Requirements
- R1: While reset is held, and on the first cycle after it, `free_cnt` equals DEPTH and no `iss_valid` bit is set.
- R2: On each clock edge, every dispatch lane whose `disp_valid` bit is set is captured. Lanes whose bit is clear are skipped. On the next cycle `free_cnt` has dropped by the number of captured lanes, less any entries issued in that same cycle.
- R3: `free_cnt` always equals DEPTH minus the number of occupied entries. It never exceeds DEPTH.
- R4: A wakeup broadcast whose tag matches a source sets that source's ready bit. This also applies when the broadcast arrives in the same cycle the instruction is dispatched. An entry whose sources are all ready can issue in the cycle after its last source becomes ready, and not earlier.
- R5: An entry whose position is WIN or above (counted from the oldest entry, at position 0) never issues, even when it is ready and ports are free.
- R6: In the out-of-order variant, a ready entry inside the window issues even while an older entry in the window is still waiting.
- R7: Ready window entries are served oldest first. The k-th oldest granted entry goes to the k-th lowest-numbered port whose `port_free` bit is set. Ready entries beyond the number of free ports wait.
- R8: `iss_valid[p]` is never set while `port_free[p]` is low.
- R9: After each edge, the surviving entries keep their relative age order and occupy the lowest positions. Entries accepted on that edge sit above them, in lane order (lane 0 oldest).
- R10: While `flush` is high, nothing issues. On the next cycle the queue is empty (`free_cnt` equals DEPTH), and any instructions dispatched in the flush cycle are discarded.
- R11: In the in-order variant, an entry is granted only when every older entry is granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Discard all entries and suppress issue this cycle |
| disp_valid | input | ACCEPT | Per-lane dispatch valid |
| disp_payload | input | ACCEPT*PAY_W | Per-lane instruction payload, lane 0 in the low bits |
| disp_src_tag | input | ACCEPT*NSRC*TAG_W | Source tags, lane-major then source |
| disp_src_rdy | input | ACCEPT*NSRC | Source ready bits at dispatch |
| wake_valid | input | NWAKE | Wakeup broadcast valid |
| wake_tag | input | NWAKE*TAG_W | Wakeup broadcast tags |
| port_free | input | NPORT | Per-port free to accept an instruction |
| iss_valid | output | NPORT | Per-port issue valid |
| iss_payload | output | NPORT*PAY_W | Per-port issued payload |
| free_cnt | output | $clog2(DEPTH+1) | Number of empty entries |

## Verification
The bench builds two copies of the queue.

The first uses the defaults: six entries, three-wide accept, a three-entry window, four ports, out of order. This lets it fill the queue completely with a ready instruction parked above the window, which exercises the window limit. It also lets three ready entries compete for only two free ports, which exercises oldest-first port mapping.

The second uses four entries, two-wide accept, a two-entry window and in-order mode. There, a ready younger entry is held behind a waiting older one until both can leave together.

// File: rtl/iq_pkg.sv
// Shared definitions for the issue queue.
// Assumes nothing beyond IEEE 1800-2017 enums.
package iq_pkg;

    // Ordering rule applied among entries of the issue window
    typedef enum logic {
        IQ_OUT_OF_ORDER = 1'b0,
        IQ_IN_ORDER     = 1'b1
    } iq_order_e;

endpackage

// File: rtl/iq_wakeup.sv
// Source-ready update for one instruction: each source's ready bit is set
// when any valid broadcast carries its tag. Purely combinational.
// Assumes tags are unique among in-flight producers.
module iq_wakeup #(
    parameter int NSRC  = 2,
    parameter int NWAKE = 2,
    parameter int TAG_W = 4
) (
    input  logic [NSRC-1:0][TAG_W-1:0]  src_tag,
    input  logic [NSRC-1:0]             src_rdy,
    input  logic [NWAKE-1:0]            wake_valid,
    input  logic [NWAKE-1:0][TAG_W-1:0] wake_tag,
    output logic [NSRC-1:0]             rdy_out
);

    // Merge stored ready bits with tag matches from every broadcast
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            rdy_out[s] = src_rdy[s];
            for (int w = 0; w < NWAKE; w++) begin
                if (wake_valid[w] && (wake_tag[w] == src_tag[s])) begin
                    rdy_out[s] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/iq_select.sv
// Oldest-first port selection for the issue window.
// Slot 0 is the oldest. Each granted slot takes the lowest free port not
// already claimed. In in-order mode, the first slot that is not granted
// blocks every younger slot.
module iq_select
    import iq_pkg::*;
#(
    parameter int        WIN   = 3,
    parameter int        NPORT = 4,
    parameter iq_order_e ORDER = IQ_OUT_OF_ORDER
) (
    input  logic [WIN-1:0]             cand,
    input  logic [NPORT-1:0]           port_free,
    output logic [WIN-1:0]             gnt,
    output logic [WIN-1:0][NPORT-1:0]  sel
);

    // Walk the window from oldest to youngest, handing out free ports
    always_comb begin
        logic [NPORT-1:0] avail;
        logic             blocked;
        logic             found;
        avail   = port_free;
        blocked = 1'b0;
        gnt     = '0;
        sel     = '0;
        for (int i = 0; i < WIN; i++) begin
            found = 1'b0;
            if (cand[i] && !blocked) begin
                for (int p = 0; p < NPORT; p++) begin
                    if (!found && avail[p]) begin
                        found     = 1'b1;
                        gnt[i]    = 1'b1;
                        sel[i][p] = 1'b1;
                        avail[p]  = 1'b0;
                    end
                end
            end
            if ((ORDER == IQ_IN_ORDER) && !gnt[i]) begin
                blocked = 1'b1;
            end
        end
    end

endmodule

// File: rtl/iq_compact.sv
// Next-state packing. Surviving entries move down to the lowest positions,
// keeping their order, and accepted lanes are stacked above them in lane order.
// Assumes survivors plus accepted lanes never exceed DEPTH; any excess is dropped.
module iq_compact #(
    parameter int DEPTH  = 6,
    parameter int ACCEPT = 3,
    parameter int ENT_W  = 16
) (
    input  logic [DEPTH-1:0]  keep,
    input  logic [ENT_W-1:0]  ent_in  [DEPTH],
    input  logic [ACCEPT-1:0] new_vld,
    input  logic [ENT_W-1:0]  new_ent [ACCEPT],
    output logic [DEPTH-1:0]  out_vld,
    output logic [ENT_W-1:0]  out_ent [DEPTH]
);

    // Rank every source by position, then route each rank to its slot
    always_comb begin
        int pos_old [DEPTH];
        int pos_new [ACCEPT];
        int k;
        k = 0;
        for (int e = 0; e < DEPTH; e++) begin
            pos_old[e] = k;
            if (keep[e]) k = k + 1;
        end
        for (int l = 0; l < ACCEPT; l++) begin
            pos_new[l] = k;
            if (new_vld[l]) k = k + 1;
        end
        out_vld = '0;
        for (int j = 0; j < DEPTH; j++) begin
            out_ent[j] = '0;
            for (int e = 0; e < DEPTH; e++) begin
                if (keep[e] && (pos_old[e] == j)) begin
                    out_vld[j] = 1'b1;
                    out_ent[j] = ent_in[e];
                end
            end
            for (int l = 0; l < ACCEPT; l++) begin
                if (new_vld[l] && (pos_new[l] == j)) begin
                    out_vld[j] = 1'b1;
                    out_ent[j] = new_ent[l];
                end
            end
        end
    end

endmodule

// File: rtl/multi_accept_issue_queue.sv
// Issue queue with multi-lane accept, wakeup, a bottom issue window and
// per-cycle compaction.
// Assumes dispatch never presents more valid lanes than free_cnt reports,
// that WIN <= DEPTH, and that entries freed by issue are reusable only from
// the next cycle.
module multi_accept_issue_queue
    import iq_pkg::*;
#(
    parameter int        DEPTH  = 6,
    parameter int        ACCEPT = 3,
    parameter int        WIN    = 3,
    parameter int        NPORT  = 4,
    parameter int        NSRC   = 2,
    parameter int        NWAKE  = 2,
    parameter int        TAG_W  = 4,
    parameter int        PAY_W  = 8,
    parameter iq_order_e ORDER  = IQ_OUT_OF_ORDER,
    localparam int       CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic [ACCEPT-1:0]             disp_valid,
    input  logic [ACCEPT*PAY_W-1:0]       disp_payload,
    input  logic [ACCEPT*NSRC*TAG_W-1:0]  disp_src_tag,
    input  logic [ACCEPT*NSRC-1:0]        disp_src_rdy,
    input  logic [NWAKE-1:0]              wake_valid,
    input  logic [NWAKE*TAG_W-1:0]        wake_tag,
    input  logic [NPORT-1:0]              port_free,
    output logic [NPORT-1:0]              iss_valid,
    output logic [NPORT*PAY_W-1:0]        iss_payload,
    output logic [CNT_W-1:0]              free_cnt
);

    localparam int TAGS_W = NSRC * TAG_W;
    localparam int TAG_LO = NSRC;
    localparam int PAY_LO = NSRC + TAGS_W;
    localparam int ENT_W  = PAY_LO + PAY_W;

    logic [DEPTH-1:0]       q_vld;
    logic [ENT_W-1:0]       q_ent     [DEPTH];
    logic [CNT_W-1:0]       q_cnt;
    logic [ENT_W-1:0]       q_ent_upd [DEPTH];
    logic [ENT_W-1:0]       lane_ent  [ACCEPT];
    logic [DEPTH-1:0]       keep;
    logic [DEPTH-1:0]       nxt_vld;
    logic [ENT_W-1:0]       nxt_ent   [DEPTH];
    logic [CNT_W-1:0]       nxt_cnt;
    logic [WIN-1:0]         cand;
    logic [WIN-1:0]         gnt;
    logic [WIN-1:0][NPORT-1:0] sel;
    logic [ACCEPT-1:0]      accept_vld;

    // Wakeup for resident entries, and carry-through of their other fields
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic [NSRC-1:0] rdy_upd;
        iq_wakeup #(.NSRC(NSRC), .NWAKE(NWAKE), .TAG_W(TAG_W)) u_wake (
            .src_tag    (q_ent[e][PAY_LO-1:TAG_LO]),
            .src_rdy    (q_ent[e][NSRC-1:0]),
            .wake_valid (wake_valid),
            .wake_tag   (wake_tag),
            .rdy_out    (rdy_upd)
        );
        assign q_ent_upd[e] = {q_ent[e][ENT_W-1:TAG_LO], rdy_upd};
    end

    // Wakeup for incoming lanes, so a same-cycle broadcast is not lost
    for (genvar l = 0; l < ACCEPT; l++) begin : g_lane
        logic [NSRC-1:0] rdy_upd;
        iq_wakeup #(.NSRC(NSRC), .NWAKE(NWAKE), .TAG_W(TAG_W)) u_wake (
            .src_tag    (disp_src_tag[l*TAGS_W +: TAGS_W]),
            .src_rdy    (disp_src_rdy[l*NSRC +: NSRC]),
            .wake_valid (wake_valid),
            .wake_tag   (wake_tag),
            .rdy_out    (rdy_upd)
        );
        assign lane_ent[l] = {disp_payload[l*PAY_W +: PAY_W],
                              disp_src_tag[l*TAGS_W +: TAGS_W], rdy_upd};
    end

    // Window candidates: valid, all sources ready as stored, no flush
    for (genvar i = 0; i < WIN; i++) begin : g_cand
        assign cand[i] = q_vld[i] && (&q_ent[i][NSRC-1:0]) && !flush;
    end

    iq_select #(.WIN(WIN), .NPORT(NPORT), .ORDER(ORDER)) u_select (
        .cand      (cand),
        .port_free (port_free),
        .gnt       (gnt),
        .sel       (sel)
    );

    // Route each granted window slot onto its port
    always_comb begin
        iss_valid   = '0;
        iss_payload = '0;
        for (int p = 0; p < NPORT; p++) begin
            for (int i = 0; i < WIN; i++) begin
                if (sel[i][p]) begin
                    iss_valid[p]                 = 1'b1;
                    iss_payload[p*PAY_W +: PAY_W] = q_ent[i][ENT_W-1:PAY_LO];
                end
            end
        end
    end

    // Survivors: valid entries not granted this cycle
    for (genvar e = 0; e < DEPTH; e++) begin : g_keep
        if (e < WIN) begin : g_win
            assign keep[e] = q_vld[e] && !gnt[e];
        end else begin : g_above
            assign keep[e] = q_vld[e];
        end
    end

    assign accept_vld = disp_valid;

    iq_compact #(.DEPTH(DEPTH), .ACCEPT(ACCEPT), .ENT_W(ENT_W)) u_compact (
        .keep    (keep),
        .ent_in  (q_ent_upd),
        .new_vld (accept_vld),
        .new_ent (lane_ent),
        .out_vld (nxt_vld),
        .out_ent (nxt_ent)
    );

    // Occupancy of the next state
    always_comb begin
        nxt_cnt = '0;
        for (int e = 0; e < DEPTH; e++) begin
            nxt_cnt = nxt_cnt + CNT_W'(nxt_vld[e]);
        end
    end

    // Valid bits and occupancy: cleared by reset or flush
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld <= '0;
            q_cnt <= '0;
        end else if (flush) begin
            q_vld <= '0;
            q_cnt <= '0;
        end else begin
            q_vld <= nxt_vld;
            q_cnt <= nxt_cnt;
        end
    end

    // Entry contents: loaded every cycle, meaningful only where valid
    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            q_ent[e] <= nxt_ent[e];
        end
    end

    assign free_cnt = CNT_W'(DEPTH) - q_cnt;

endmodule

// File: rtl/iq_checker.sv
// Port-level properties of the issue queue, attached by bind.
// Assumes dispatch respects free_cnt whenever the occupancy rule is applied.
module iq_checker #(
    parameter int DEPTH  = 6,
    parameter int ACCEPT = 3,
    parameter int NPORT  = 4,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic [ACCEPT-1:0] disp_valid,
    input logic [NPORT-1:0]  port_free,
    input logic [NPORT-1:0]  iss_valid,
    input logic [CNT_W-1:0]  free_cnt
);

    p_free_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_cnt) <= DEPTH);

    p_busy_port_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid & ~port_free) == '0);

    p_empty_no_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(free_cnt) == DEPTH) |-> (iss_valid == '0));

    p_flush_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (iss_valid == '0));

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (int'(free_cnt) == DEPTH));

    p_occupancy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && ($countones(disp_valid) <= int'(free_cnt)))
        |=> (int'(free_cnt) == int'($past(free_cnt)) + $countones($past(iss_valid))
                               - $countones($past(disp_valid))));

endmodule

bind multi_accept_issue_queue iq_checker #(
    .DEPTH  (DEPTH),
    .ACCEPT (ACCEPT),
    .NPORT  (NPORT),
    .CNT_W  (CNT_W)
) u_iq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .disp_valid (disp_valid),
    .port_free  (port_free),
    .iss_valid  (iss_valid),
    .free_cnt   (free_cnt)
);

// File: tb/multi_accept_issue_queue_bench.sv
// Bench: a vector table walked by one loop, then directed tests on an
// out-of-order instance (defaults) and an in-order instance.
module multi_accept_issue_queue_bench;
    import iq_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int total = 0;
    int bad   = 0;

    // Out-of-order instance, default parameters
    logic        flush;
    logic [2:0]  disp_valid;
    logic [23:0] disp_payload;
    logic [23:0] disp_src_tag;
    logic [5:0]  disp_src_rdy;
    logic [1:0]  wake_valid;
    logic [7:0]  wake_tag;
    logic [3:0]  port_free;
    logic [3:0]  iss_valid;
    logic [31:0] iss_payload;
    logic [2:0]  free_cnt;

    multi_accept_issue_queue u_multi_accept_issue_queue (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_payload(disp_payload),
        .disp_src_tag(disp_src_tag), .disp_src_rdy(disp_src_rdy),
        .wake_valid(wake_valid), .wake_tag(wake_tag),
        .port_free(port_free), .iss_valid(iss_valid),
        .iss_payload(iss_payload), .free_cnt(free_cnt)
    );

    // In-order instance: four entries, two-wide accept, two-entry window
    logic        b_flush;
    logic [1:0]  b_disp_valid;
    logic [15:0] b_disp_payload;
    logic [15:0] b_disp_src_tag;
    logic [3:0]  b_disp_src_rdy;
    logic [1:0]  b_wake_valid;
    logic [7:0]  b_wake_tag;
    logic [3:0]  b_port_free;
    logic [3:0]  b_iss_valid;
    logic [31:0] b_iss_payload;
    logic [2:0]  b_free_cnt;

    multi_accept_issue_queue #(
        .DEPTH(4), .ACCEPT(2), .WIN(2), .NPORT(4), .ORDER(IQ_IN_ORDER)
    ) u_multi_accept_issue_queue_ino (
        .clk(clk), .rst_n(rst_n), .flush(b_flush),
        .disp_valid(b_disp_valid), .disp_payload(b_disp_payload),
        .disp_src_tag(b_disp_src_tag), .disp_src_rdy(b_disp_src_rdy),
        .wake_valid(b_wake_valid), .wake_tag(b_wake_tag),
        .port_free(b_port_free), .iss_valid(b_iss_valid),
        .iss_payload(b_iss_payload), .free_cnt(b_free_cnt)
    );

    typedef struct packed {
        logic [1:0]  n;
        logic [7:0]  base;
        logic [3:0]  pf;
        logic [2:0]  free;
        logic [3:0]  iss;
        logic [31:0] pays;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{2'd3, 8'h10, 4'b0000, 3'd6, 4'b0000, 32'h0000_0000},
        '{2'd3, 8'h13, 4'b0000, 3'd3, 4'b0000, 32'h0000_0000},
        '{2'd0, 8'h00, 4'b1111, 3'd0, 4'b0111, 32'h0012_1110},
        '{2'd0, 8'h00, 4'b0101, 3'd3, 4'b0101, 32'h0014_0013},
        '{2'd0, 8'h00, 4'b1010, 3'd5, 4'b0010, 32'h0000_1500},
        '{2'd0, 8'h00, 4'b1111, 3'd6, 4'b0000, 32'h0000_0000}
    };

    task automatic check(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr();
        flush = 1'b0; disp_valid = '0; disp_payload = '0;
        disp_src_tag = '0; disp_src_rdy = '0; wake_valid = '0;
        wake_tag = '0; port_free = 4'hF;
        b_flush = 1'b0; b_disp_valid = '0; b_disp_payload = '0;
        b_disp_src_tag = '0; b_disp_src_rdy = '0; b_wake_valid = '0;
        b_wake_tag = '0; b_port_free = 4'hF;
    endtask

    task automatic lane(input int l, input logic [7:0] pay,
                        input logic [3:0] t0, input logic [3:0] t1,
                        input logic r0, input logic r1);
        disp_valid[l]              = 1'b1;
        disp_payload[l*8 +: 8]     = pay;
        disp_src_tag[l*8 +: 8]     = {t1, t0};
        disp_src_rdy[l*2 +: 2]     = {r1, r0};
    endtask

    task automatic b_lane(input int l, input logic [7:0] pay,
                          input logic [3:0] t0, input logic [3:0] t1,
                          input logic r0, input logic r1);
        b_disp_valid[l]            = 1'b1;
        b_disp_payload[l*8 +: 8]   = pay;
        b_disp_src_tag[l*8 +: 8]   = {t1, t0};
        b_disp_src_rdy[l*2 +: 2]   = {r1, r0};
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int pay_of(input logic [31:0] bus, input int p);
        return int'(bus[p*8 +: 8]);
    endfunction

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clr();
        repeat (3) tick();
        // R1: reset state
        check(int'(free_cnt), 6, "R1 free_cnt in reset");
        check(int'(iss_valid), 0, "R1 iss_valid in reset");
        rst_n = 1'b1;
        #1;
        check(int'(free_cnt), 6, "R1 free_cnt after reset");
        check(int'(b_free_cnt), 4, "R1 in-order free_cnt after reset");

        // Table: fill, busy ports (R8), oldest-first port mapping (R7),
        // occupancy (R3), compaction order (R9)
        for (int r = 0; r < 6; r++) begin
            clr();
            for (int l = 0; l < int'(VEC[r].n); l++) begin
                lane(l, VEC[r].base + 8'(l), 4'd0, 4'd0, 1'b1, 1'b1);
            end
            port_free = VEC[r].pf;
            #1;
            check(int'(free_cnt), int'(VEC[r].free), "R3 free_cnt row");
            check(int'(iss_valid), int'(VEC[r].iss), "R7 R8 iss_valid row");
            for (int p = 0; p < 4; p++) begin
                if (VEC[r].iss[p]) begin
                    check(pay_of(iss_payload, p), pay_of(VEC[r].pays, p),
                          "R9 R7 payload row");
                end
            end
            tick();
        end

        // R2: lane 1 idle, lanes 0 and 2 captured in order
        clr();
        lane(0, 8'h70, 4'd0, 4'd0, 1'b1, 1'b1);
        lane(2, 8'h72, 4'd0, 4'd0, 1'b1, 1'b1);
        disp_payload[15:8] = 8'h71;
        port_free = 4'b0000;
        tick();
        clr();
        #1;
        check(int'(free_cnt), 4, "R2 free_cnt after sparse accept");
        check(int'(iss_valid), 4'b0011, "R2 iss_valid sparse");
        check(pay_of(iss_payload, 0), 8'h70, "R2 port0 payload");
        check(pay_of(iss_payload, 1), 8'h72, "R2 port1 payload");
        tick();

        // R4: two staggered wakeups, issue only the cycle after the last one
        clr();
        lane(0, 8'h40, 4'd3, 4'd5, 1'b0, 1'b0);
        tick();
        clr();
        wake_valid = 2'b01; wake_tag = 8'h03;
        #1;
        check(int'(iss_valid), 0, "R4 not ready before wakeup");
        tick();
        clr();
        wake_valid = 2'b10; wake_tag = 8'h50;
        #1;
        check(int'(iss_valid), 0, "R4 one source still waiting");
        tick();
        clr();
        #1;
        check(int'(iss_valid), 1, "R4 issue after last wakeup");
        check(pay_of(iss_payload, 0), 8'h40, "R4 payload");
        tick();
        // R4: broadcast in the dispatch cycle is captured
        clr();
        lane(0, 8'h41, 4'd7, 4'd7, 1'b0, 1'b0);
        wake_valid = 2'b01; wake_tag = 8'h07;
        tick();
        clr();
        #1;
        check(int'(iss_valid), 1, "R4 same-cycle wakeup issue");
        check(pay_of(iss_payload, 0), 8'h41, "R4 same-cycle payload");
        tick();

        // R5: ready entry above the window waits
        clr();
        lane(0, 8'h50, 4'd9, 4'd9, 1'b0, 1'b0);
        lane(1, 8'h51, 4'd9, 4'd9, 1'b0, 1'b0);
        lane(2, 8'h52, 4'd9, 4'd9, 1'b0, 1'b0);
        tick();
        clr();
        lane(0, 8'h53, 4'd0, 4'd0, 1'b1, 1'b1);
        tick();
        clr();
        wake_valid = 2'b01; wake_tag = 8'h09;
        #1;
        check(int'(iss_valid), 0, "R5 slot above window held");
        check(int'(free_cnt), 2, "R3 free_cnt with four entries");
        tick();
        clr();
        #1;
        check(int'(iss_valid), 4'b0111, "R7 window drains oldest first");
        check(pay_of(iss_payload, 0), 8'h50, "R7 port0 oldest");
        check(pay_of(iss_payload, 2), 8'h52, "R7 port2 third");
        tick();
        clr();
        #1;
        check(int'(iss_valid), 1, "R9 shifted entry issues");
        check(pay_of(iss_payload, 0), 8'h53, "R9 shifted payload");
        tick();

        // R6: younger ready entry bypasses older waiting ones
        clr();
        lane(0, 8'h60, 4'd10, 4'd10, 1'b0, 1'b0);
        lane(1, 8'h61, 4'd0, 4'd0, 1'b1, 1'b1);
        lane(2, 8'h62, 4'd11, 4'd11, 1'b0, 1'b0);
        tick();
        clr();
        wake_valid = 2'b01; wake_tag = 8'h0A;
        #1;
        check(int'(iss_valid), 1, "R6 younger issues first");
        check(pay_of(iss_payload, 0), 8'h61, "R6 payload");
        tick();

        // R10: flush while an entry is ready; dispatch in that cycle dropped
        clr();
        flush = 1'b1;
        lane(0, 8'h63, 4'd0, 4'd0, 1'b1, 1'b1);
        #1;
        check(int'(iss_valid), 0, "R10 no issue during flush");
        tick();
        clr();
        #1;
        check(int'(free_cnt), 6, "R10 empty after flush");
        check(int'(iss_valid), 0, "R10 nothing left to issue");
        tick();

        // R11: in-order variant holds a ready younger entry
        clr();
        b_lane(0, 8'h80, 4'd12, 4'd12, 1'b0, 1'b0);
        b_lane(1, 8'h81, 4'd0, 4'd0, 1'b1, 1'b1);
        tick();
        clr();
        b_wake_valid = 2'b01; b_wake_tag = 8'h0C;
        #1;
        check(int'(b_iss_valid), 0, "R11 younger held behind older");
        check(int'(b_free_cnt), 2, "R11 in-order occupancy");
        tick();
        clr();
        #1;
        check(int'(b_iss_valid), 4'b0011, "R11 both issue together");
        check(pay_of(b_iss_payload, 0), 8'h80, "R11 older on port0");
        check(pay_of(b_iss_payload, 1), 8'h81, "R11 younger on port1");
        tick();
        #1;
        check(int'(b_free_cnt), 4, "R11 in-order drained");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule